// File: doc/BRIEF.md
# PWM Timer with Repeat, One-Shot and Half-Step Modes

The block is a 16-bit up-counter with two compare values. It produces a compare A pulse, a compare B pulse and a PWM waveform. A compare B match brings the counter back to 0, so compare B sets the PWM period. Compare A sets the point in each period where the PWM output falls. The counter advances only on cycles where the count-clock enable is high, so a prescaler outside the block sets the count rate.

There are two count modes. In repeat mode the counter runs until the run input is cleared. In one-shot mode it stops by itself at the first compare B match. In half-step mode each enable pulse is treated as half a count period. The position becomes the count plus a half-step bit, and compare A takes an extra half bit, which gives twice the duty resolution. In capture configuration the block only counts: it generates no compare events and holds the PWM output low.

Top module: `pwm_timer`

## Requirements
- R1: After reset, `cnt_o` is 0, `half_o` is 0, and `pwm_o`, `cmp_a_o` and `cmp_b_o` are all 0.
- R2: In repeat mode (`oneshot_i`=0) the counter advances on every enabled step. A step taken at count `cmp_b_i` loads 0 instead, and counting continues.
- R3: In one-shot mode (`oneshot_i`=1) the step at the compare B match loads 0 and halts the counter. While halted, further enables change neither the count nor the outputs.
- R4: In normal mode (`halfclk_i`=0), a step taken while `cnt_o` equals `cmp_a_i` raises `cmp_a_o` for exactly one cycle after that step. `half_o` stays 0.
- R5: The counter holds its value on any cycle where `cnt_en_i` is 0 or `run_i` is 0.
- R6: In half-step mode (`halfclk_i`=1) each step toggles `half_o`. `cnt_o` advances when `half_o` goes from 1 to 0. Compare A fires at position {`cmp_a_i`,`cmp_a_half_i`}. Compare B fires at position {`cmp_b_i`,1}.
- R7: `pwm_o` is set to 1 by a start or a compare B match. It is cleared to 0 by a compare A match. When both match on the same step, the clear wins.
- R8: A rising edge on `run_i` restarts counting from 0 on that cycle, without taking a step. This also releases a halted one-shot counter.
- R9: When `capture_i`=1, no compare pulses are produced and `pwm_o` is 0. The counter wraps from 0xFFFF to 0.
- R10: `cmp_b_o` is only ever high in a cycle where the counter reads 0 with `half_o` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Run level; a rising edge restarts from 0 |
| oneshot_i | input | 1 | 1 selects one-shot mode, 0 selects repeat mode |
| halfclk_i | input | 1 | 1 selects half-step counting |
| capture_i | input | 1 | 1 selects capture configuration (no compare, no PWM) |
| cnt_en_i | input | 1 | Count step enable |
| cmp_a_i | input | 16 | Compare A count value |
| cmp_a_half_i | input | 1 | Compare A half-step bit (half-step mode only) |
| cmp_b_i | input | 16 | Compare B count value (period end) |
| cnt_o | output | 16 | Counter value |
| half_o | output | 1 | Half-step bit |
| cmp_a_o | output | 1 | Compare A pulse |
| cmp_b_o | output | 1 | Compare B pulse |
| pwm_o | output | 1 | PWM output |

## Verification
The assertions assume that the mode inputs (`halfclk_i`, `oneshot_i`, `capture_i`) change only while `run_i` is low. They also assume that a mode switch is followed by a fresh rising edge on `run_i`. The stimulus respects this: it drops `run_i` and reprograms the modes and compare values before each new scenario. The compare values are chosen so that compare A and compare B never coincide, except where the clear priority of R7 is the thing under test.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int unsigned CNT_W = 16;

  typedef struct packed {
    logic oneshot;
    logic halfclk;
    logic capture;
  } mode_t;
endpackage

// File: rtl/pwm_compare.sv
module pwm_compare #(
  parameter int unsigned W = 16
) (
  input  logic         capture_i,
  input  logic         halfclk_i,
  input  logic [W-1:0] cnt_i,
  input  logic         half_i,
  input  logic [W-1:0] cmp_a_i,
  input  logic         cmp_a_half_i,
  input  logic [W-1:0] cmp_b_i,
  output logic         hit_a_o,
  output logic         hit_b_o
);
  logic eq_a, eq_b;

  assign eq_a = (cnt_i == cmp_a_i);
  assign eq_b = (cnt_i == cmp_b_i);

  always_comb begin
    if (capture_i) begin
      hit_a_o = 1'b0;
      hit_b_o = 1'b0;
    end else if (halfclk_i) begin
      hit_a_o = eq_a && (half_i == cmp_a_half_i);
      hit_b_o = eq_b && half_i;  // period ends on the second half of count B
    end else begin
      hit_a_o = eq_a;
      hit_b_o = eq_b;
    end
  end
endmodule

// File: rtl/pwm_step_counter.sv
module pwm_step_counter
  import pwm_timer_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         cnt_en_i,
  input  mode_t        mode_i,
  input  logic         hit_b_i,
  output logic [W-1:0] cnt_o,
  output logic         half_o,
  output logic         start_o,
  output logic         step_o
);
  logic [W-1:0] cnt_q;
  logic         half_q, done_q, run_q;

  assign start_o = run_i && !run_q;
  assign step_o  = run_i && !run_q ? 1'b0 : (run_i && cnt_en_i && !done_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
      done_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      run_q <= run_i;
      if (start_o) begin
        cnt_q  <= '0;
        half_q <= 1'b0;
        done_q <= 1'b0;
      end else if (step_o) begin
        if (hit_b_i) begin
          cnt_q  <= '0;
          half_q <= 1'b0;
          done_q <= mode_i.oneshot;
        end else if (mode_i.halfclk) begin
          half_q <= !half_q;
          if (half_q) cnt_q <= cnt_q + 1'b1;
        end else begin
          cnt_q  <= cnt_q + 1'b1;  // wraps at all-ones
          half_q <= 1'b0;
        end
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign half_o = half_q;

  a_r5_enable_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_en_i && !start_o) |=> $stable(cnt_q) && $stable(half_q));

  a_r3_oneshot_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !start_o) |=> $stable(cnt_q) && $stable(half_q));

  a_r4_normal_no_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i.halfclk && !half_q) |=> !half_q);
endmodule

// File: rtl/pwm_wave.sv
module pwm_wave (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic capture_i,
  input  logic start_i,
  input  logic step_i,
  input  logic hit_a_i,
  input  logic hit_b_i,
  output logic cmp_a_o,
  output logic cmp_b_o,
  output logic pwm_o
);
  logic a_q, b_q, pwm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= 1'b0;
      b_q   <= 1'b0;
      pwm_q <= 1'b0;
    end else begin
      a_q <= step_i && hit_a_i;
      b_q <= step_i && hit_b_i;
      if (start_i)                 pwm_q <= 1'b1;
      else if (step_i && hit_a_i)  pwm_q <= 1'b0;  // clear wins over set
      else if (step_i && hit_b_i)  pwm_q <= 1'b1;
    end
  end

  assign cmp_a_o = a_q;
  assign cmp_b_o = b_q;
  assign pwm_o   = pwm_q && !capture_i;

  a_r7_fall_on_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_q && !capture_i) |-> !pwm_o);
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         oneshot_i,
  input  logic         halfclk_i,
  input  logic         capture_i,
  input  logic         cnt_en_i,
  input  logic [W-1:0] cmp_a_i,
  input  logic         cmp_a_half_i,
  input  logic [W-1:0] cmp_b_i,
  output logic [W-1:0] cnt_o,
  output logic         half_o,
  output logic         cmp_a_o,
  output logic         cmp_b_o,
  output logic         pwm_o
);
  mode_t        mode;
  logic [W-1:0] cnt;
  logic         half, start, step, hit_a, hit_b;

  assign mode = '{oneshot: oneshot_i, halfclk: halfclk_i, capture: capture_i};

  pwm_compare #(.W(W)) u_cmp (
    .capture_i   (mode.capture),
    .halfclk_i   (mode.halfclk),
    .cnt_i       (cnt),
    .half_i      (half),
    .cmp_a_i     (cmp_a_i),
    .cmp_a_half_i(cmp_a_half_i),
    .cmp_b_i     (cmp_b_i),
    .hit_a_o     (hit_a),
    .hit_b_o     (hit_b)
  );

  pwm_step_counter #(.W(W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_i),
    .cnt_en_i(cnt_en_i),
    .mode_i  (mode),
    .hit_b_i (hit_b),
    .cnt_o   (cnt),
    .half_o  (half),
    .start_o (start),
    .step_o  (step)
  );

  pwm_wave u_wave (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(mode.capture),
    .start_i  (start),
    .step_i   (step),
    .hit_a_i  (hit_a),
    .hit_b_i  (hit_b),
    .cmp_a_o  (cmp_a_o),
    .cmp_b_o  (cmp_b_o),
    .pwm_o    (pwm_o)
  );

  assign cnt_o  = cnt;
  assign half_o = half;

  a_r10_b_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_b_o |-> (cnt_o == '0) && !half_o);

  a_r8_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |=> (cnt_o == '0) && !half_o && !cmp_a_o && !cmp_b_o);
endmodule

// File: tb/pwm_timer_bench.sv
module pwm_timer_bench;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        run_i = 0, oneshot_i = 0, halfclk_i = 0, capture_i = 0, cnt_en_i = 0;
  logic [15:0] cmp_a_i = '0, cmp_b_i = '0;
  logic        cmp_a_half_i = 0;
  logic [15:0] cnt_o;
  logic        half_o, cmp_a_o, cmp_b_o, pwm_o;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  pwm_timer u_pwm_timer (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic start(logic os, logic hc, logic cap, logic [15:0] a, logic ah, logic [15:0] b);
    @(negedge clk_i); run_i = 0; cnt_en_i = 0;
    @(negedge clk_i);
    oneshot_i = os; halfclk_i = hc; capture_i = cap;
    cmp_a_i = a; cmp_a_half_i = ah; cmp_b_i = b;
    @(negedge clk_i); run_i = 1; cnt_en_i = 1;
    tick();
    chk("R8 start cnt", cnt_o, 0);
    chk("R7 start pwm", pwm_o, !cap);
  endtask

  // repeat-mode waveform over n steps: R2 R4 R6 R7
  task automatic t_pattern(logic hc, int a, logic ah, int b, int n);
    int per = hc ? 2*b+2 : b+1;
    int th  = hc ? 2*a+ah : a;
    start(0, hc, 0, a[15:0], ah, b[15:0]);
    for (int k = 1; k <= n; k++) begin
      int p = k % per;
      tick();
      chk(hc ? "R6 cnt" : "R2 cnt", cnt_o, hc ? p/2 : p);
      chk(hc ? "R6 half" : "R4 half", half_o, hc ? p%2 : 0);
      chk("R7 pwm", pwm_o, p <= th);
      chk("R4 cmp_a", cmp_a_o, p == (th+1) % per);
      chk("R10 cmp_b", cmp_b_o, p == 0);
    end
  endtask

  task automatic t_oneshot();
    start(1, 0, 0, 1, 0, 3);
    repeat (4) tick();
    chk("R3 at B cnt", cnt_o, 0);
    chk("R3 at B pulse", cmp_b_o, 1);
    for (int k = 0; k < 6; k++) begin
      tick();
      chk("R3 halted cnt", cnt_o, 0);
      chk("R3 halted pulses", {cmp_a_o, cmp_b_o}, 0);
      chk("R3 halted pwm", pwm_o, 1);
    end
    start(1, 0, 0, 1, 0, 3);   // R8 restart releases halt
    tick();
    chk("R8 restart counts", cnt_o, 1);
  endtask

  task automatic t_hold();
    start(0, 0, 0, 5, 0, 9);
    repeat (3) tick();
    @(negedge clk_i); cnt_en_i = 0;
    repeat (3) tick();
    chk("R5 enable low hold", cnt_o, 3);
    @(negedge clk_i); cnt_en_i = 1; run_i = 0;
    repeat (2) tick();
    chk("R5 run low hold", cnt_o, 3);
  endtask

  task automatic t_tie();
    start(0, 0, 0, 2, 0, 2);   // A and B coincide: clear wins
    repeat (3) tick();
    chk("R7 tie cnt", cnt_o, 0);
    chk("R7 tie pwm low", pwm_o, 0);
    chk("R7 tie both pulses", {cmp_a_o, cmp_b_o}, 2'b11);
    tick();
    chk("R4 pulse one cycle", cmp_a_o, 0);
  endtask

  task automatic t_capture();
    int bad = 0;
    start(0, 0, 1, 1, 0, 2);
    for (int k = 1; k <= 65540; k++) begin
      tick();
      if (cmp_a_o || cmp_b_o || pwm_o) bad++;
    end
    chk("R9 no events or pwm", bad, 0);
    chk("R9 wrap cnt", cnt_o, 4);
  endtask

  initial begin
    #12;
    chk("R1 cnt", cnt_o, 0);
    chk("R1 outs", {half_o, pwm_o, cmp_a_o, cmp_b_o}, 0);
    @(negedge clk_i); rst_ni = 1;
    t_pattern(0, 2, 0, 4, 12);
    t_pattern(0, 0, 0, 3, 9);
    t_pattern(1, 1, 1, 2, 14);
    t_pattern(1, 0, 0, 3, 18);
    t_oneshot();
    t_hold();
    t_tie();
    t_capture();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=%0d exp=done", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule